// File: doc/BRIEF.md
# Wake-on-LAN magic packet detector

This block watches the bytes of one received Ethernet frame at a time and raises a wake-up indication when the frame carries a magic packet. A magic packet is six bytes of 0xFF followed at once by sixteen unbroken copies of the station's own 48-bit address. The bytes must already have the preamble removed. The first byte of the stream is the first byte of the destination address. CRC checking is done elsewhere.

Detection runs in two cases. In full power it runs when the enable input is set. In low power it runs without the enable input. While detection runs, the block drives a gate output that tells the normal receive path to drop frames. Only frames addressed to this station, to broadcast or to a multicast group are examined. The search for the sync begins after the two address fields. The sync-plus-copies sequence may start anywhere in the payload. If the run of copies breaks, the search for a new sync resumes in the same frame.

A hit sets a sticky status bit. That bit drives either the interrupt line or the power-management event line, chosen by a select pin. The host clears the bit with a one-cycle write-1 pulse.

The byte stream has no back-pressure. The detector takes a byte on every clock in which `rx_valid` is high. It never stalls the source, so it has no ready output. Idle cycles between bytes are allowed anywhere in a frame.

Top module: `wol_magic_detect`

## Requirements
- R1: `rx_block` is high exactly when `det_enable` or `low_power` is high. When both are low, no frame sets the status.
- R2: A frame is examined only if its destination matches `station_addr`, or its first destination byte has bit 0 set (multicast, which includes broadcast). Any other unicast destination never sets the status.
- R3: The sync is six consecutive 0xFF bytes. It counts only from frame byte 12 onward, so 0xFF in the address fields never forms a sync.
- R4: After the sync, 16 consecutive copies of the address must follow. Each copy is sent as `station_addr[47:40]` first and `station_addr[7:0]` last. The status reads 1 in the cycle after the clock edge that takes the 96th copy byte.
- R5: A wrong byte inside the copies aborts the attempt. That same byte is tested as the first byte of a new sync. A 0xFF run longer than six still counts as a sync.
- R6: The sync-plus-copies sequence is detected at any byte offset in the payload.
- R7: The status stays set until `status_clr` is pulsed. If a hit and a clear arrive in the same cycle, the status stays set.
- R8: `irq_out` equals the status when `notify_sel` is 0. `pme_out` equals the status when `notify_sel` is 1. The unselected line stays low.
- R9: `rx_sof` clears all match state. The sequence must complete on or before the byte marked `rx_eof`. Bytes that arrive after `rx_eof` and before the next `rx_sof` are ignored.
- R10: With `low_power` high and `det_enable` low, magic packets are still detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe, one byte taken per high cycle |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| station_addr | input | 48 | Station address, bits 47:40 sent first |
| det_enable | input | 1 | Detection enable in full power |
| low_power | input | 1 | Low-power state, forces detection on |
| notify_sel | input | 1 | 0 routes status to irq_out, 1 routes it to pme_out |
| status_clr | input | 1 | Write-1-to-clear pulse for the status |
| mp_status | output | 1 | Sticky magic packet received status |
| irq_out | output | 1 | Host interrupt |
| pme_out | output | 1 | Power-management event |
| rx_block | output | 1 | Blocks normal receive delivery |

## Verification
If the internal sync or copy counters hold a wrong value, no wrong value is visible at the ports at first. It shows only as a missed or false status at the end of a frame: at the 96th copy byte, or when the frame ends. So every check of a frame is made right after its last byte. Sync runs with a break, and frames cut short at one copy, expose a counter that is off by one. A destination filter that keeps stale state shows up on the next frame: a unicast frame for another station sets the status.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int ADDR_BYTES_DEF = 6;
  localparam int SYNC_LEN_DEF   = 6;
  localparam int COPIES_DEF     = 16;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/wol_dest_filter.sv
module wol_dest_filter #(
  parameter int ADDR_BYTES = wol_pkg::ADDR_BYTES_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_eof,
  input  logic [7:0]              in_data,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  output logic                    frame_start,
  output logic                    pay_valid
);
  localparam int HDR = 2 * ADDR_BYTES;
  localparam int PW  = $clog2(HDR + 1);
  localparam int AW  = $clog2(ADDR_BYTES);

  logic [7:0]    addr_b [ADDR_BYTES];
  logic [PW-1:0] pos, cur;
  logic          in_frame, own_ok, grp_ok, take, own_nx;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_bytes
    assign addr_b[g] = station_addr[8*(ADDR_BYTES-1-g) +: 8];
  end

  assign frame_start = in_valid & in_sof;
  assign take        = in_valid & (in_sof | in_frame);
  assign cur         = in_sof ? '0 : pos;
  assign own_nx      = ((cur == '0) ? 1'b1 : own_ok) &
                       (cur < PW'(ADDR_BYTES)) &&
                       (in_data == addr_b[cur[AW-1:0]]);
  assign pay_valid   = take & (cur == PW'(HDR)) & (own_ok | grp_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      in_frame <= 1'b0;
      own_ok   <= 1'b0;
      grp_ok   <= 1'b0;
    end else if (take) begin
      in_frame <= ~in_eof;
      if (cur < PW'(HDR)) pos <= cur + 1'b1;
      if (cur < PW'(ADDR_BYTES)) own_ok <= own_nx;
      if (cur == '0) grp_ok <= in_data[0];
    end
  end

  assert_pos_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= PW'(HDR));
  assert_sof_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !in_eof |=> in_frame && pos == PW'(1));
endmodule

// File: rtl/wol_pattern_scan.sv
module wol_pattern_scan #(
  parameter int ADDR_BYTES = wol_pkg::ADDR_BYTES_DEF,
  parameter int SYNC_LEN   = wol_pkg::SYNC_LEN_DEF,
  parameter int COPIES     = wol_pkg::COPIES_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    clear,
  input  logic                    pay_valid,
  input  logic [7:0]              in_data,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  output logic                    hit
);
  localparam int SW = $clog2(SYNC_LEN + 1);
  localparam int AW = $clog2(ADDR_BYTES);
  localparam int CW = $clog2(COPIES);

  logic [7:0]    addr_b [ADDR_BYTES];
  logic [SW-1:0] sync_cnt;
  logic [AW-1:0] byte_idx;
  logic [CW-1:0] copy_idx;
  logic          synced, is_sync, match, last_b, last_c, run_start;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_bytes
    assign addr_b[g] = station_addr[8*(ADDR_BYTES-1-g) +: 8];
  end

  assign synced    = (sync_cnt == SW'(SYNC_LEN));
  assign is_sync   = (in_data == wol_pkg::SYNC_BYTE);
  assign match     = (in_data == addr_b[byte_idx]);
  assign last_b    = (byte_idx == AW'(ADDR_BYTES - 1));
  assign last_c    = (copy_idx == CW'(COPIES - 1));
  assign run_start = (byte_idx == '0) && (copy_idx == '0);
  assign hit       = en & pay_valid & synced & match & last_b & last_c;

  always_ff @(posedge clk) begin
    if (!rst_n || !en || clear) begin
      sync_cnt <= '0;
      byte_idx <= '0;
      copy_idx <= '0;
    end else if (pay_valid) begin
      if (!synced) begin
        sync_cnt <= is_sync ? sync_cnt + 1'b1 : '0;
      end else if (match) begin
        if (last_b) begin
          byte_idx <= '0;
          if (last_c) begin
            copy_idx <= '0;
            sync_cnt <= '0;
          end else begin
            copy_idx <= copy_idx + 1'b1;
          end
        end else begin
          byte_idx <= byte_idx + 1'b1;
        end
      end else if (!(run_start && is_sync)) begin
        byte_idx <= '0;
        copy_idx <= '0;
        sync_cnt <= is_sync ? SW'(1) : '0;
      end
    end
  end

  assert_sync_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_cnt <= SW'(SYNC_LEN));
  assert_clear_on_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> sync_cnt == '0 && copy_idx == '0 && byte_idx == '0);
  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> sync_cnt == '0);
  assert_break_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clear && pay_valid && synced && !match && !(run_start && is_sync)
    |=> copy_idx == '0 && byte_idx == '0);
endmodule

// File: rtl/wol_notify.sv
module wol_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic status_clr,
  input  logic notify_sel,
  output logic mp_status,
  output logic irq_out,
  output logic pme_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) mp_status <= 1'b0;
    else        mp_status <= hit | (mp_status & ~status_clr);
  end

  assign irq_out = mp_status & ~notify_sel;
  assign pme_out = mp_status &  notify_sel;

  assert_hit_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> mp_status);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mp_status && !status_clr |=> mp_status);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr && !hit |=> !mp_status);
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect #(
  parameter int ADDR_BYTES = wol_pkg::ADDR_BYTES_DEF,
  parameter int SYNC_LEN   = wol_pkg::SYNC_LEN_DEF,
  parameter int COPIES     = wol_pkg::COPIES_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic                    det_enable,
  input  logic                    low_power,
  input  logic                    notify_sel,
  input  logic                    status_clr,
  output logic                    mp_status,
  output logic                    irq_out,
  output logic                    pme_out,
  output logic                    rx_block
);
  logic detect_on, frame_start, pay_valid, hit;

  assign detect_on = det_enable | low_power;
  assign rx_block  = detect_on;

  wol_dest_filter #(.ADDR_BYTES(ADDR_BYTES)) u_filter (
    .clk, .rst_n,
    .in_valid(rx_valid), .in_sof(rx_sof), .in_eof(rx_eof), .in_data(rx_data),
    .station_addr, .frame_start, .pay_valid
  );

  wol_pattern_scan #(.ADDR_BYTES(ADDR_BYTES), .SYNC_LEN(SYNC_LEN), .COPIES(COPIES)) u_scan (
    .clk, .rst_n, .en(detect_on), .clear(frame_start), .pay_valid,
    .in_data(rx_data), .station_addr, .hit
  );

  wol_notify u_notify (
    .clk, .rst_n, .hit, .status_clr, .notify_sel, .mp_status, .irq_out, .pme_out
  );

  assert_no_hit_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !detect_on && !mp_status && !status_clr |=> !mp_status);
endmodule

// File: tb/wol_magic_detect_bench.sv
module wol_magic_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0]  rx_data = '0;
  logic [47:0] station_addr = 48'h0211_2233_4455;
  logic        det_enable = 0, low_power = 0, notify_sel = 0, status_clr = 0;
  logic        mp_status, irq_out, pme_out, rx_block;

  int n_tests = 0, n_fail = 0;
  logic [7:0] fr [0:255];
  int flen;

  always #4 clk = ~clk;

  wol_magic_detect u_wol_magic_detect (
    .clk, .rst_n, .rx_valid, .rx_sof, .rx_eof, .rx_data, .station_addr,
    .det_enable, .low_power, .notify_sel, .status_clr,
    .mp_status, .irq_out, .pme_out, .rx_block
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ab(input int i);
    return station_addr[8*(5-i) +: 8];
  endfunction

  // frame building
  task automatic fb_start(input int kind); // 0 own, 1 broadcast, 2 multicast, 3 other unicast
    for (int i = 0; i < 6; i++) begin
      case (kind)
        0: fr[i] = ab(i);
        1: fr[i] = 8'hFF;
        2: fr[i] = (i == 0) ? (8'h01 | 8'($urandom)) : 8'($urandom);
        default: fr[i] = (i == 0) ? (ab(0) ^ 8'h02) : 8'($urandom);
      endcase
    end
    for (int i = 6; i < 12; i++) fr[i] = 8'($urandom % 255);
    flen = 12;
  endtask
  task automatic fb_add(input logic [7:0] b); fr[flen] = b; flen++; endtask
  task automatic fb_ff(input int n); for (int i = 0; i < n; i++) fb_add(8'hFF); endtask
  task automatic fb_copies(input int n);
    for (int c = 0; c < n; c++) for (int i = 0; i < 6; i++) fb_add(ab(i));
  endtask

  // reference: exists an offset with sync then 16 copies inside the frame
  function automatic bit ref_magic();
    bit dok, ok;
    dok = fr[0][0];
    if (!dok) begin
      dok = 1;
      for (int i = 0; i < 6; i++) if (fr[i] != ab(i)) dok = 0;
    end
    if (!dok) return 0;
    for (int p = 12; p + 102 <= flen; p++) begin
      ok = 1;
      for (int k = 0; k < 6; k++) if (fr[p+k] != 8'hFF) ok = 0;
      for (int k = 0; k < 96; k++) if (fr[p+6+k] != ab(k % 6)) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  task automatic send(input bit with_sof, input bit gaps, input bit clr_last);
    for (int i = 0; i < flen; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk); rx_valid = 0;
      end
      @(negedge clk);
      rx_valid = 1; rx_data = fr[i];
      rx_sof = with_sof && (i == 0);
      rx_eof = (i == flen - 1);
      status_clr = clr_last && (i == flen - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; status_clr = 0;
  endtask

  task automatic clear_status();
    @(negedge clk); status_clr = 1;
    @(negedge clk); status_clr = 0;
  endtask

  task automatic expect_status(input string req, input bit exp);
    check(req, mp_status, exp);
    check(req, irq_out, exp & ~notify_sel);
    check(req, pme_out, exp & notify_sel);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset status", mp_status, 0);
    check("R8 reset irq", irq_out, 0);
    check("R8 reset pme", pme_out, 0);
    check("R1 reset gate", rx_block, 0);

    // R1: detection off
    fb_start(0); fb_ff(6); fb_copies(16);
    send(1, 0, 0);
    expect_status("R1 disabled", 0);
    det_enable = 1; #1;
    check("R1 gate on", rx_block, 1);

    // R4 basic
    fb_start(0); fb_ff(6); fb_copies(16); fb_add(8'h12);
    send(1, 0, 0);
    expect_status("R4 basic irq", 1);
    repeat (5) @(negedge clk);
    check("R7 sticky", mp_status, 1);
    clear_status();
    check("R7 cleared", mp_status, 0);

    // R4 timing: one copy byte short of completion, then the final byte
    fb_start(0); fb_ff(6); fb_copies(16);
    for (int i = 0; i < flen - 1; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = fr[i]; rx_sof = (i == 0); rx_eof = 0;
    end
    @(negedge clk); check("R4 before last byte", mp_status, 0);
    rx_data = fr[flen-1]; rx_eof = 1;
    @(negedge clk); rx_valid = 0; rx_eof = 0;
    check("R4 after 96th byte", mp_status, 1);
    clear_status();

    // R8 pme routing
    notify_sel = 1;
    fb_start(1); fb_ff(6); fb_copies(16);
    send(1, 1, 0);
    expect_status("R8 pme route / R2 broadcast", 1);
    clear_status();
    notify_sel = 0;

    // R2 other unicast
    fb_start(3); fb_ff(6); fb_copies(16);
    send(1, 0, 0);
    expect_status("R2 other unicast", 0);
    fb_start(2); fb_ff(6); fb_copies(16);
    send(1, 0, 0);
    expect_status("R2 multicast", 1);
    clear_status();

    // R3 FF in source field does not sync
    fb_start(0);
    for (int i = 6; i < 12; i++) fr[i] = 8'hFF;
    fb_copies(16);
    send(1, 0, 0);
    expect_status("R3 sync in header", 0);

    // R5 break with FF, then new sync
    fb_start(0); fb_ff(6); fb_copies(3); fb_add(ab(0)); fb_add(ab(1));
    fb_ff(6); fb_copies(16);
    send(1, 0, 0);
    expect_status("R5 break byte is sync", 1);
    clear_status();
    fb_start(0); fb_ff(9); fb_copies(16);
    send(1, 0, 0);
    expect_status("R5 long sync run", 1);
    clear_status();
    fb_start(0); fb_ff(6); fb_copies(7); fb_add(8'h5A); fb_copies(9);
    send(1, 0, 0);
    expect_status("R5 broken run", 0);

    // R6 offset
    fb_start(0);
    for (int i = 0; i < 37; i++) fb_add(8'($urandom % 255));
    fb_ff(6); fb_copies(16); fb_add(8'h00);
    send(1, 1, 0);
    expect_status("R6 offset", 1);
    clear_status();

    // R9 short, split across frames, sof-less bytes
    fb_start(0); fb_ff(6); fb_copies(15); for (int i = 0; i < 5; i++) fb_add(ab(i));
    send(1, 0, 0);
    expect_status("R9 ends early", 0);
    fb_start(0); fb_copies(8);
    send(1, 0, 0);
    expect_status("R9 no carry across frames", 0);
    fb_start(0); fb_ff(6); fb_copies(16);
    send(0, 0, 0);
    expect_status("R9 bytes outside frame", 0);

    // R7 set wins over clear
    fb_start(0); fb_ff(6); fb_copies(16);
    send(1, 0, 1);
    check("R7 set wins", mp_status, 1);
    clear_status();

    // R10 low power
    det_enable = 0; low_power = 1; #1;
    check("R10 gate", rx_block, 1);
    fb_start(0); fb_ff(6); fb_copies(16);
    send(1, 0, 0);
    expect_status("R10 low power detect", 1);
    clear_status();
    low_power = 0; det_enable = 1;

    // random frames
    for (int t = 0; t < 150; t++) begin
      bit exp;
      int plen;
      station_addr = {8'($urandom % 255) & 8'hFE, 8'($urandom % 255), 8'($urandom % 255),
                      8'($urandom % 255), 8'($urandom % 255), 8'($urandom % 255)};
      notify_sel = $urandom % 2;
      fb_start($urandom % 4);
      if ($urandom % 2) begin
        plen = $urandom % 60;
        for (int i = 0; i < plen; i++) fb_add(($urandom % 8 == 0) ? 8'hFF : 8'($urandom));
        fb_ff(6); fb_copies(16);
        if ($urandom % 3 == 0) fr[12 + plen + ($urandom % 102)] = 8'($urandom);
        if ($urandom % 2) flen = flen - ($urandom % 3);
      end else begin
        plen = $urandom % 160;
        for (int i = 0; i < plen; i++) fb_add(($urandom % 4 == 0) ? 8'hFF : 8'($urandom));
      end
      exp = ref_magic();
      send(1, 1, 0);
      expect_status(exp ? "R4 random hit" : "R5 random miss", exp);
      clear_status();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule